// File: doc/BRIEF.md
# Performance Event to Counter Steering Table

This block keeps a small associative table that records which programmable hardware counter is assigned to each performance event. Control logic writes a counter index together with a 64-bit event-select word. The block checks the write, then installs a new assignment, releases every assignment that targets that counter, ignores the write, or refuses it. A refusal is flagged in the same cycle.

Event sources present a 20-bit event identifier on the lookup port. In the same cycle the block answers whether that event is assigned and, if so, to which counter, so that an increment pulse can be routed there. A second query port reports whether a given counter index currently counts clock cycles or retired instructions. This covers the two fixed counters as well as any programmable counter that has been assigned one of those two events.

Top module: `evmap_table`

## Requirements
- R1: After a synchronous active-low reset the table holds no assignments. A lookup misses, and the query port reports cycles only for index 0 and instructions only for index 2.
- R2: The event identifier is bits [19:0] of the written word, and bits [63:20] are ignored when the word is non-zero. A non-zero word whose low 20 bits are zero is refused.
- R3: A write is refused (`wr_err`=1, table unchanged) when the counter index is below 3, is not below `NUM_CTRS`, or has its bit clear in `avail_mask`. This holds for zero words as well.
- R4: Only the identifiers 0x00001 (cycles), 0x00002 (instructions), 0x10019, 0x1001B and 0x10021 can be installed. Identifiers are {type[3:0], code[15:0]}, and for the last three the code is {cache[12:0], op[1:0], result}. Any other identifier is refused and nothing is installed.
- R5: A write whose identifier is already assigned is accepted without error and leaves the existing assignment unchanged, so the first writer wins.
- R6: A zero write to a valid counter is accepted and removes every assignment that targets that counter. This includes the case where no assignment targets it.
- R7: A lookup is combinational. `lk_hit`=1 with the assigned index when the event is assigned; otherwise `lk_hit`=0 and `lk_ctr`=0. A reported index is never below 3.
- R8: A new assignment takes the lowest free entry. When all `ENTRIES` entries are in use, the write is refused. An entry freed by R6 can be reused.
- R9: `q_is_instr` is 1 when `q_ctr` is 2, or when `q_ctr` equals the counter assigned to identifier 0x00002.
- R10: `q_is_cycles` is 1 when `q_ctr` is 0, or when `q_ctr` equals the counter assigned to identifier 0x00001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| avail_mask | input | NUM_CTRS | One bit per counter that may be a target |
| wr_en | input | 1 | Write strobe |
| wr_ctr | input | CW | Counter index of the write |
| wr_value | input | 64 | Event-select word; zero releases the counter |
| wr_err | output | 1 | Write refused (same cycle as wr_en) |
| lk_event | input | 20 | Event identifier to look up |
| lk_hit | output | 1 | Event is assigned |
| lk_ctr | output | CW | Assigned counter index, zero on miss |
| q_ctr | input | CW | Counter index being queried |
| q_is_cycles | output | 1 | Queried counter counts cycles |
| q_is_instr | output | 1 | Queried counter counts instructions |

## Verification
The checker watches, on every cycle, that refused writes leave the table untouched. It also checks that out-of-range indices are always refused and that zero writes to valid counters are never refused. Lookup misses must report index zero, hits must never name a counter below 3, and the fixed indices 0 and 2 must always answer the cycle and instruction queries. The bench scenarios are what show first-writer-wins, the whitelist, the masking of the upper word bits, release of several assignments to one counter, table exhaustion, and reuse of a freed entry.

// File: rtl/evmap_pkg.sv
`timescale 1ns/1ps
// evmap_pkg: shared encodings for the event steering table.
// Assumes event identifiers are {type[3:0], code[15:0]}.
package evmap_pkg;
    localparam int EV_W = 20;

    localparam logic [EV_W-1:0] EV_CYCLES     = 20'h00001;
    localparam logic [EV_W-1:0] EV_INSTR      = 20'h00002;
    localparam logic [EV_W-1:0] EV_DTLB_RD_MS = 20'h10019;
    localparam logic [EV_W-1:0] EV_DTLB_WR_MS = 20'h1001B;
    localparam logic [EV_W-1:0] EV_ITLB_MS    = 20'h10021;

    // Decision taken for one write.
    typedef enum logic [1:0] {
        OP_NONE    = 2'd0,
        OP_UNMAP   = 2'd1,
        OP_INSTALL = 2'd2,
        OP_REJECT  = 2'd3
    } wr_op_e;

    // True for the identifiers the table accepts.
    function automatic logic is_known_event(input logic [EV_W-1:0] ev);
        return (ev == EV_CYCLES) || (ev == EV_INSTR) ||
               (ev == EV_DTLB_RD_MS) || (ev == EV_DTLB_WR_MS) ||
               (ev == EV_ITLB_MS);
    endfunction
endpackage

// File: rtl/evmap_match.sv
`timescale 1ns/1ps
// evmap_match: compares one key against every entry.
// Returns the hit and the counter of the lowest matching entry.
// Assumes at most one valid entry holds a given key.
module evmap_match
    import evmap_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int CW      = 5
) (
    input  logic [ENTRIES-1:0]           ent_valid,
    input  logic [ENTRIES-1:0][EV_W-1:0] ent_event,
    input  logic [ENTRIES-1:0][CW-1:0]   ent_ctr,
    input  logic [EV_W-1:0]              key,
    output logic                         hit,
    output logic [CW-1:0]                ctr
);
    // Scan the entries from high to low so the lowest match wins.
    always_comb begin
        hit = 1'b0;
        ctr = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (ent_valid[i] && ent_event[i] == key) begin
                hit = 1'b1;
                ctr = ent_ctr[i];
            end
        end
    end
endmodule

// File: rtl/evmap_first_free.sv
`timescale 1ns/1ps
// evmap_first_free: finds the lowest-numbered unused entry.
// Assumes SW is wide enough to number ENTRIES slots.
module evmap_first_free #(
    parameter int ENTRIES = 4,
    parameter int SW      = 2
) (
    input  logic [ENTRIES-1:0] ent_valid,
    output logic               any_free,
    output logic [SW-1:0]      slot
);
    // Priority encode the free entries with the lowest index winning.
    always_comb begin
        any_free = 1'b0;
        slot     = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!ent_valid[i]) begin
                any_free = 1'b1;
                slot     = SW'(i);
            end
        end
    end
endmodule

// File: rtl/evmap_wr_check.sv
`timescale 1ns/1ps
// evmap_wr_check: classifies a write as install, release, ignore or refuse.
// Assumes key_hit and any_free reflect the table before the write commits.
module evmap_wr_check
    import evmap_pkg::*;
#(
    parameter int NUM_CTRS = 32,
    parameter int CW       = 5
) (
    input  logic                wr_en,
    input  logic [CW-1:0]       wr_ctr,
    input  logic [63:0]         wr_value,
    input  logic [NUM_CTRS-1:0] avail_mask,
    input  logic                key_hit,
    input  logic                any_free,
    output wr_op_e              op
);
    localparam int FIRST_PROG = 3;

    logic ctr_ok;

    // A target must be programmable, in range and marked available.
    always_comb begin
        ctr_ok = (int'(wr_ctr) >= FIRST_PROG) && (int'(wr_ctr) < NUM_CTRS) &&
                 avail_mask[wr_ctr];
    end

    // Decide the action, checks ordered by precedence.
    always_comb begin
        if (!wr_en)                              op = OP_NONE;
        else if (!ctr_ok)                        op = OP_REJECT;
        else if (wr_value == 64'd0)              op = OP_UNMAP;
        else if (key_hit)                        op = OP_NONE;
        else if (!is_known_event(wr_value[EV_W-1:0])) op = OP_REJECT;
        else if (!any_free)                      op = OP_REJECT;
        else                                     op = OP_INSTALL;
    end
endmodule

// File: rtl/evmap_store.sv
`timescale 1ns/1ps
// evmap_store: the entry registers of the table.
// Installs into one chosen slot, or clears every entry that targets a counter.
// Assumes op is OP_INSTALL only when ins_slot is free.
module evmap_store
    import evmap_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int CW      = 5,
    parameter int SW      = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  wr_op_e                        op,
    input  logic [SW-1:0]                 ins_slot,
    input  logic [EV_W-1:0]               ins_event,
    input  logic [CW-1:0]                 tgt_ctr,
    output logic [ENTRIES-1:0]            ent_valid,
    output logic [ENTRIES-1:0][EV_W-1:0]  ent_event,
    output logic [ENTRIES-1:0][CW-1:0]    ent_ctr
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        // Hold one assignment: reset, install, or release by counter.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_valid[g] <= 1'b0;
                ent_event[g] <= '0;
                ent_ctr[g]   <= '0;
            end else if (op == OP_INSTALL && ins_slot == SW'(g)) begin
                ent_valid[g] <= 1'b1;
                ent_event[g] <= ins_event;
                ent_ctr[g]   <= tgt_ctr;
            end else if (op == OP_UNMAP && ent_valid[g] && ent_ctr[g] == tgt_ctr) begin
                ent_valid[g] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/evmap_table.sv
`timescale 1ns/1ps
// evmap_table: event-to-counter steering table with write checking,
// single-cycle lookup, and cycle/instruction counter queries.
// Assumes NUM_CTRS is a power of two so CW numbers every counter.
module evmap_table
    import evmap_pkg::*;
#(
    parameter int NUM_CTRS = 32,
    parameter int ENTRIES  = 4,
    parameter int CW       = $clog2(NUM_CTRS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_CTRS-1:0] avail_mask,
    input  logic                wr_en,
    input  logic [CW-1:0]       wr_ctr,
    input  logic [63:0]         wr_value,
    output logic                wr_err,
    input  logic [EV_W-1:0]     lk_event,
    output logic                lk_hit,
    output logic [CW-1:0]       lk_ctr,
    input  logic [CW-1:0]       q_ctr,
    output logic                q_is_cycles,
    output logic                q_is_instr
);
    localparam int SW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [CW-1:0] FIX_CYC = CW'(0);
    localparam logic [CW-1:0] FIX_INS = CW'(2);

    logic [ENTRIES-1:0]           ent_valid;
    logic [ENTRIES-1:0][EV_W-1:0] ent_event;
    logic [ENTRIES-1:0][CW-1:0]   ent_ctr;
    logic                         key_hit;
    logic [CW-1:0]                key_ctr;
    logic                         any_free;
    logic [SW-1:0]                free_slot;
    wr_op_e                       op;
    logic                         cyc_hit, ins_hit;
    logic [CW-1:0]                cyc_ctr, ins_ctr;

    evmap_store #(.ENTRIES(ENTRIES), .CW(CW), .SW(SW)) store_i (
        .clk(clk), .rst_n(rst_n), .op(op), .ins_slot(free_slot),
        .ins_event(wr_value[EV_W-1:0]), .tgt_ctr(wr_ctr),
        .ent_valid(ent_valid), .ent_event(ent_event), .ent_ctr(ent_ctr)
    );

    evmap_first_free #(.ENTRIES(ENTRIES), .SW(SW)) free_i (
        .ent_valid(ent_valid), .any_free(any_free), .slot(free_slot)
    );

    evmap_match #(.ENTRIES(ENTRIES), .CW(CW)) m_wr_i (
        .ent_valid(ent_valid), .ent_event(ent_event), .ent_ctr(ent_ctr),
        .key(wr_value[EV_W-1:0]), .hit(key_hit), .ctr(key_ctr)
    );

    evmap_match #(.ENTRIES(ENTRIES), .CW(CW)) m_lk_i (
        .ent_valid(ent_valid), .ent_event(ent_event), .ent_ctr(ent_ctr),
        .key(lk_event), .hit(lk_hit), .ctr(lk_ctr)
    );

    evmap_match #(.ENTRIES(ENTRIES), .CW(CW)) m_cyc_i (
        .ent_valid(ent_valid), .ent_event(ent_event), .ent_ctr(ent_ctr),
        .key(EV_CYCLES), .hit(cyc_hit), .ctr(cyc_ctr)
    );

    evmap_match #(.ENTRIES(ENTRIES), .CW(CW)) m_ins_i (
        .ent_valid(ent_valid), .ent_event(ent_event), .ent_ctr(ent_ctr),
        .key(EV_INSTR), .hit(ins_hit), .ctr(ins_ctr)
    );

    evmap_wr_check #(.NUM_CTRS(NUM_CTRS), .CW(CW)) chk_wr_i (
        .wr_en(wr_en), .wr_ctr(wr_ctr), .wr_value(wr_value),
        .avail_mask(avail_mask), .key_hit(key_hit), .any_free(any_free),
        .op(op)
    );

    // Flag a refused write in the cycle it is presented.
    always_comb wr_err = (op == OP_REJECT);

    // Answer the counter-role queries from fixed indices and the table.
    always_comb begin
        q_is_cycles = (q_ctr == FIX_CYC) || (cyc_hit && cyc_ctr == q_ctr);
        q_is_instr  = (q_ctr == FIX_INS) || (ins_hit && ins_ctr == q_ctr);
    end

    logic unused_key;
    always_comb unused_key = ^key_ctr;
endmodule

// File: rtl/evmap_table_chk.sv
`timescale 1ns/1ps
// evmap_table_chk: cycle-by-cycle properties of evmap_table, bound below.
module evmap_table_chk
    import evmap_pkg::*;
#(
    parameter int NUM_CTRS = 32,
    parameter int ENTRIES  = 4,
    parameter int CW       = $clog2(NUM_CTRS)
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [NUM_CTRS-1:0]           avail_mask,
    input logic                          wr_en,
    input logic [CW-1:0]                 wr_ctr,
    input logic [63:0]                   wr_value,
    input logic                          wr_err,
    input logic                          lk_hit,
    input logic [CW-1:0]                 lk_ctr,
    input logic [CW-1:0]                 q_ctr,
    input logic                          q_is_cycles,
    input logic                          q_is_instr,
    input logic [ENTRIES-1:0]            ent_valid,
    input logic [ENTRIES-1:0][EV_W-1:0]  ent_event,
    input logic [ENTRIES-1:0][CW-1:0]    ent_ctr
);
    a_r3_low_index_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(wr_ctr) < 3) |-> wr_err);

    a_r3_refusal_keeps_table: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_err) |=> ($stable(ent_valid) && $stable(ent_event) && $stable(ent_ctr)));

    a_r6_release_accepted: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_value == 64'd0 && int'(wr_ctr) >= 3 && avail_mask[wr_ctr]) |-> !wr_err);

    a_r7_miss_reports_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_ctr == '0));

    a_r7_hit_target_programmable: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (int'(lk_ctr) >= 3));

    a_r9_fixed_instr: assert property (@(posedge clk) disable iff (!rst_n)
        (q_ctr == CW'(2)) |-> q_is_instr);

    a_r10_fixed_cycles: assert property (@(posedge clk) disable iff (!rst_n)
        (q_ctr == CW'(0)) |-> q_is_cycles);
endmodule

bind evmap_table evmap_table_chk #(.NUM_CTRS(NUM_CTRS), .ENTRIES(ENTRIES), .CW(CW)) chk_i (.*);

// File: tb/evmap_table_tb_top.sv
`timescale 1ns/1ps
module evmap_table_tb_top;
    localparam int NUM_CTRS = 32;
    localparam int ENTRIES  = 4;
    localparam int CW       = 5;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [NUM_CTRS-1:0] avail_mask = 32'h0000_07F8;
    logic                wr_en = 1'b0;
    logic [CW-1:0]       wr_ctr = '0;
    logic [63:0]         wr_value = '0;
    logic                wr_err;
    logic [19:0]         lk_event = '0;
    logic                lk_hit;
    logic [CW-1:0]       lk_ctr;
    logic [CW-1:0]       q_ctr = '0;
    logic                q_is_cycles, q_is_instr;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    evmap_table #(.NUM_CTRS(NUM_CTRS), .ENTRIES(ENTRIES)) dut_i (
        .clk(clk), .rst_n(rst_n), .avail_mask(avail_mask),
        .wr_en(wr_en), .wr_ctr(wr_ctr), .wr_value(wr_value), .wr_err(wr_err),
        .lk_event(lk_event), .lk_hit(lk_hit), .lk_ctr(lk_ctr),
        .q_ctr(q_ctr), .q_is_cycles(q_is_cycles), .q_is_instr(q_is_instr)
    );

    // kind 0: write error, 1: lookup, 2: query
    typedef struct {
        int          kind;
        logic        exp_a;
        logic        exp_b;
        logic [CW-1:0] exp_ctr;
        string       tag;
    } item_t;

    item_t sb_q[$];

    task automatic drive_wr(input logic [CW-1:0] c, input logic [63:0] v,
                            input logic exp_err, input string tag);
        item_t it;
        @(negedge clk); #1;
        wr_en = 1'b1; wr_ctr = c; wr_value = v;
        it.kind = 0; it.exp_a = exp_err; it.exp_b = 1'b0; it.exp_ctr = '0; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic drive_lk(input logic [19:0] ev, input logic exp_hit,
                            input logic [CW-1:0] exp_c, input string tag);
        item_t it;
        @(negedge clk); #1;
        wr_en = 1'b0; lk_event = ev;
        it.kind = 1; it.exp_a = exp_hit; it.exp_b = 1'b0; it.exp_ctr = exp_c; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic drive_q(input logic [CW-1:0] c, input logic exp_cyc,
                           input logic exp_ins, input string tag);
        item_t it;
        @(negedge clk); #1;
        wr_en = 1'b0; q_ctr = c;
        it.kind = 2; it.exp_a = exp_cyc; it.exp_b = exp_ins; it.exp_ctr = '0; it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: pop expected items and compare with the outputs mid-cycle.
    initial begin
        forever begin
            @(negedge clk); #3;
            while (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                checks++;
                if (it.kind == 0) begin
                    if (wr_err !== it.exp_a) begin
                        errors++;
                        $display("FAIL %s: wr_err=%0b expected %0b", it.tag, wr_err, it.exp_a);
                    end
                end else if (it.kind == 1) begin
                    if (lk_hit !== it.exp_a || lk_ctr !== it.exp_ctr) begin
                        errors++;
                        $display("FAIL %s: hit=%0b ctr=%0d expected hit=%0b ctr=%0d",
                                 it.tag, lk_hit, lk_ctr, it.exp_a, it.exp_ctr);
                    end
                end else begin
                    if (q_is_cycles !== it.exp_a || q_is_instr !== it.exp_b) begin
                        errors++;
                        $display("FAIL %s: cyc=%0b ins=%0b expected cyc=%0b ins=%0b",
                                 it.tag, q_is_cycles, q_is_instr, it.exp_a, it.exp_b);
                    end
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state, plus fixed counters for R9 and R10
        drive_lk(20'h00001, 1'b0, 5'd0, "R1 empty lookup");
        drive_q(5'd0, 1'b1, 1'b0, "R1 R10 index 0 counts cycles");
        drive_q(5'd2, 1'b0, 1'b1, "R1 R9 index 2 counts instructions");
        drive_q(5'd5, 1'b0, 1'b0, "R1 index 5 idle");

        // R3 invalid targets
        drive_wr(5'd2, 64'd1, 1'b1, "R3 index below 3");
        drive_wr(5'd11, 64'd1, 1'b1, "R3 index masked off");
        drive_wr(5'd0, 64'd0, 1'b1, "R3 zero write to index 0");
        drive_lk(20'h00001, 1'b0, 5'd0, "R3 nothing installed");

        // R2 upper bits ignored; R7 lookup
        drive_wr(5'd5, 64'hABCD_0000_0000_0001, 1'b0, "R2 upper bits ignored");
        drive_lk(20'h00001, 1'b1, 5'd5, "R7 cycles event to 5");
        drive_q(5'd5, 1'b1, 1'b0, "R10 counter 5 counts cycles");

        // R5 first writer wins
        drive_wr(5'd6, 64'd1, 1'b0, "R5 duplicate accepted");
        drive_lk(20'h00001, 1'b1, 5'd5, "R5 mapping kept");

        // R4 whitelist, R2 zero identifier
        drive_wr(5'd6, 64'h3, 1'b1, "R4 unknown event");
        drive_lk(20'h00003, 1'b0, 5'd0, "R4 unknown not installed");
        drive_wr(5'd6, 64'hFFFF_0000_0000_0000, 1'b1, "R2 zero identifier refused");

        // R9 instructions mapping
        drive_wr(5'd6, 64'h2, 1'b0, "R9 install instructions");
        drive_q(5'd6, 1'b0, 1'b1, "R9 counter 6 counts instructions");
        drive_q(5'd2, 1'b0, 1'b1, "R9 fixed index still true");

        // R8 fill table then overflow
        drive_wr(5'd7, 64'h10019, 1'b0, "R4 install data TLB read miss");
        drive_wr(5'd8, 64'h1001B, 1'b0, "R4 install data TLB write miss");
        drive_wr(5'd9, 64'h10021, 1'b1, "R8 table full");
        drive_lk(20'h10021, 1'b0, 5'd0, "R8 not installed when full");

        // R6 release
        drive_wr(5'd6, 64'd0, 1'b0, "R6 release counter 6");
        drive_lk(20'h00002, 1'b0, 5'd0, "R6 instructions released");
        drive_q(5'd6, 1'b0, 1'b0, "R9 counter 6 no longer instructions");
        drive_lk(20'h00001, 1'b1, 5'd5, "R6 other mapping kept");

        // R8 reuse
        drive_wr(5'd9, 64'h10021, 1'b0, "R8 freed entry reused");
        drive_lk(20'h10021, 1'b1, 5'd9, "R8 reused entry hit");

        // R6 release of several entries on one counter
        drive_wr(5'd7, 64'd0, 1'b0, "R6 release counter 7");
        drive_lk(20'h10019, 1'b0, 5'd0, "R6 counter 7 released");
        drive_wr(5'd5, 64'h2, 1'b0, "R6 second event on counter 5");
        drive_wr(5'd5, 64'd0, 1'b0, "R6 release counter 5");
        drive_lk(20'h00001, 1'b0, 5'd0, "R6 cycles released");
        drive_lk(20'h00002, 1'b0, 5'd0, "R6 instructions released");
        drive_q(5'd5, 1'b0, 1'b0, "R10 counter 5 idle");
        drive_wr(5'd3, 64'd0, 1'b0, "R6 release of unused counter");
        drive_lk(20'h1001B, 1'b1, 5'd8, "R6 unrelated entry kept");

        @(negedge clk); #1; wr_en = 1'b0;
        repeat (2) @(negedge clk);
        #5;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule